// File: doc/BRIEF.md
# NAND Flash Register Bridge

This block sits on a simple request/acknowledge host bus and turns accesses to one 32-bit register into raw NAND flash bus cycles. A host write holds three fields: a chip-enable bit, a three-bit operation code and a byte. Depending on the operation code, the block runs a command latch cycle, an address latch cycle or a data write strobe, or it enters streaming read mode.

In read mode, each host read of the register runs one read-enable pulse on the flash. The read returns the byte sampled on the rising edge of that pulse, together with the live state of the flash ready/busy pin. Software reaches a whole flash page by writing command and address bytes one at a time, then streaming data bytes in or out with one register access per byte.

All strobe widths and setup/hold times are parameters counted in system clocks. The host waits on the acknowledge, so the host timing does not depend on flash timing. The flash data bus is split into output, output-enable and input wires, and the pad that joins them lies outside the block.

Top module: `nand_reg_bridge`

## Requirements
- R1: While reset is held, and after it is released with no access yet, chip enable, write strobe and read strobe are all high (inactive), command latch and address latch are low, and the data output enable is low.
- R2: A host write with bits 30:28 equal to 0 runs a command cycle. Command latch is high and address latch is low while the write strobe pulses once, and the data output carries bits 23:16 of the word.
- R3: A host write with bits 30:28 equal to 1 runs an address cycle. Address latch is high and command latch is low during the single write strobe pulse, and the data output carries bits 23:16.
- R4: A host write with bits 30:28 equal to 3 produces exactly one write strobe pulse. During that pulse both latches are low, the output enable is high and the data output carries bits 23:16.
- R5: Bit 31 of each host write sets chip enable. A value of 1 drives chip enable low and a value of 0 drives it high, and the new value is already in force during the flash cycle that the same write starts.
- R6: A host write with bits 30:28 equal to 2 enters read mode. Each host read in read mode produces one read strobe pulse and returns in bits 23:16 the flash byte sampled as that strobe rises, so successive reads return successive flash bytes.
- R7: Every host read returns in bit 15 the value 1 when the ready/busy input is low (busy) and 0 when it is high (ready). Bits 31:24 and 14:0 read as 0.
- R8: The write strobe stays low for T_WE_LO clocks. Latches and data are set up T_SETUP clocks before the write strobe falls and held for the longer of T_WE_HI and T_HOLD clocks after it rises. The read strobe stays low for T_RE_LO clocks and high for T_RE_HI clocks before the access completes. The latches and the data output do not change while the write strobe is low.
- R9: The data output enable is high only during the setup, strobe and hold phases of a command, address or data write. It is never high while the read strobe is low.
- R10: Any host write whose operation code is not 2 leaves read mode. A host read outside read mode produces no read strobe and returns the last captured byte.
- R11: A host write with an operation code from 4 to 7 changes only chip enable. It produces no strobe and does not enable the data output.
- R12: A host access is acknowledged by a single-cycle acknowledge. For a flash write cycle this comes T_SETUP + T_WE_LO + max(T_WE_HI, T_HOLD) clocks after acceptance. For a read in read mode it comes T_RE_LO + T_RE_HI clocks after acceptance. Every other access is acknowledged in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_wr | input | 1 | 1 for a register write, 0 for a register read |
| host_wdata | input | 32 | Register write word |
| host_rdata | output | 32 | Register read word, valid with the acknowledge |
| host_ack | output | 1 | Single-cycle access completion |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Flash command latch enable |
| nf_ale | output | 1 | Flash address latch enable |
| nf_we_n | output | 1 | Flash write strobe, active low |
| nf_re_n | output | 1 | Flash read strobe, active low |
| nf_dq_o | output | 8 | Flash data bus output value |
| nf_dq_oe | output | 1 | Flash data bus output enable |
| nf_dq_i | input | 8 | Flash data bus input value |
| nf_rb_n | input | 1 | Flash ready/busy, low while busy |

## Verification
The operation field is tried with all four defined codes and with codes from the ignored range. A flash model records the latch levels, the driven byte and the chip enable during each write strobe, which shows whether a command, an address or a data write was decoded. The same records show that the ignored codes raise no strobe. Streaming reads run against a flash model whose bytes change with each read strobe, so a skipped or repeated strobe gives a wrong value. A read after leaving read mode separates the streaming path from the held-byte path. The ready/busy pin is read at both levels, and access latencies and strobe widths are measured against the timing parameters.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    localparam logic [2:0] OP_CMD   = 3'd0;
    localparam logic [2:0] OP_ADDR  = 3'd1;
    localparam logic [2:0] OP_READ  = 3'd2;
    localparam logic [2:0] OP_WDATA = 3'd3;

    // Host register layout: enable bit, opcode, spare, byte, status half
    typedef struct packed {
        logic              ce;
        logic [2:0]        op;
        logic [3:0]        spare;
        logic [BYTE_W-1:0] dbyte;
        logic              busy;
        logic [14:0]       low;
    } host_word_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HIGH
    } phase_t;

    function automatic logic op_runs_we(input logic [2:0] op);
        return (op == OP_CMD) || (op == OP_ADDR) || (op == OP_WDATA);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nbr_pulse_seq.sv
module nbr_pulse_seq
    import nbr_pkg::*;
#(
    parameter int T_SETUP = 2,
    parameter int T_WE_LO = 2,
    parameter int T_WE_HI = 2,
    parameter int T_HOLD  = 2,
    parameter int T_RE_LO = 2,
    parameter int T_RE_HI = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_rd,
    output logic busy,
    output logic we_low,
    output logic re_low,
    output logic drive,
    output logic sample,
    output logic done
);

    localparam int T_WTAIL = imax(T_WE_HI, T_HOLD);
    localparam int T_MAX   = imax(imax(imax(T_SETUP, T_WE_LO), imax(T_WTAIL, T_RE_LO)), T_RE_HI);
    localparam int CW      = $clog2(T_MAX + 1);

    localparam logic [CW-1:0] L_SETUP = CW'(T_SETUP - 1);
    localparam logic [CW-1:0] L_WLO   = CW'(T_WE_LO - 1);
    localparam logic [CW-1:0] L_WTAIL = CW'(T_WTAIL - 1);
    localparam logic [CW-1:0] L_RLO   = CW'(T_RE_LO - 1);
    localparam logic [CW-1:0] L_RHI   = CW'(T_RE_HI - 1);

    phase_t        ph;
    logic [CW-1:0] cnt;
    logic          rd_q;
    logic          last;

    assign last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            rd_q <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_IDLE: if (start) begin
                    rd_q <= start_rd;
                    if (start_rd) begin
                        ph  <= PH_LOW;
                        cnt <= L_RLO;
                    end else begin
                        ph  <= PH_SETUP;
                        cnt <= L_SETUP;
                    end
                end
                PH_SETUP: if (last) begin
                    ph  <= PH_LOW;
                    cnt <= L_WLO;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_LOW: if (last) begin
                    ph  <= PH_HIGH;
                    cnt <= rd_q ? L_RHI : L_WTAIL;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: if (last) begin
                    ph   <= PH_IDLE;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    assign busy   = (ph != PH_IDLE);
    assign we_low = (ph == PH_LOW) && !rd_q;
    assign re_low = (ph == PH_LOW) && rd_q;
    assign drive  = busy && !rd_q;
    assign sample = re_low && last;

endmodule

// File: rtl/nbr_rdata.sv
module nbr_rdata
    import nbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [BYTE_W-1:0] dq_i,
    input  logic              rb_n,
    output logic [WORD_W-1:0] rdata
);

    logic [BYTE_W-1:0] cap_q;
    host_word_t        word;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else if (sample) begin
            cap_q <= dq_i;
        end
    end

    always_comb begin
        word       = '0;
        word.dbyte = cap_q;
        word.busy  = !rb_n;
        rdata      = word;
    end

endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
    import nbr_pkg::*;
#(
    parameter int T_SETUP = 2,
    parameter int T_WE_LO = 2,
    parameter int T_WE_HI = 2,
    parameter int T_HOLD  = 2,
    parameter int T_RE_LO = 2,
    parameter int T_RE_HI = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              host_ack,
    output logic              nf_ce_n,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic [BYTE_W-1:0] nf_dq_o,
    output logic              nf_dq_oe,
    input  logic [BYTE_W-1:0] nf_dq_i,
    input  logic              nf_rb_n
);

    host_word_t        w;
    logic              unused_fields;
    logic              accept;
    logic              seq_start;
    logic              seq_busy, seq_we, seq_re, seq_drive, seq_sample, seq_done;
    logic              ce_q, rdmode_q, cle_q, ale_q, ack_q;
    logic [BYTE_W-1:0] byte_q;

    assign w             = host_word_t'(host_wdata);
    assign unused_fields = ^{w.spare, w.busy, w.low};

    assign accept    = host_req && !seq_busy && !host_ack;
    assign seq_start = accept && (host_wr ? op_runs_we(w.op) : rdmode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q     <= 1'b0;
            rdmode_q <= 1'b0;
            cle_q    <= 1'b0;
            ale_q    <= 1'b0;
            ack_q    <= 1'b0;
            byte_q   <= '0;
        end else begin
            ack_q <= 1'b0;
            if (accept) begin
                if (host_wr) begin
                    ce_q     <= w.ce;
                    rdmode_q <= (w.op == OP_READ);
                    if (op_runs_we(w.op)) begin
                        cle_q  <= (w.op == OP_CMD);
                        ale_q  <= (w.op == OP_ADDR);
                        byte_q <= w.dbyte;
                    end else begin
                        ack_q <= 1'b1;
                    end
                end else if (!rdmode_q) begin
                    ack_q <= 1'b1;
                end
            end
        end
    end

    nbr_pulse_seq #(
        .T_SETUP (T_SETUP),
        .T_WE_LO (T_WE_LO),
        .T_WE_HI (T_WE_HI),
        .T_HOLD  (T_HOLD),
        .T_RE_LO (T_RE_LO),
        .T_RE_HI (T_RE_HI)
    ) i_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (seq_start),
        .start_rd (!host_wr),
        .busy     (seq_busy),
        .we_low   (seq_we),
        .re_low   (seq_re),
        .drive    (seq_drive),
        .sample   (seq_sample),
        .done     (seq_done)
    );

    nbr_rdata i_rdata (
        .clk    (clk),
        .rst    (rst),
        .sample (seq_sample),
        .dq_i   (nf_dq_i),
        .rb_n   (nf_rb_n),
        .rdata  (host_rdata)
    );

    assign host_ack = ack_q || seq_done;
    assign nf_ce_n  = !ce_q;
    assign nf_cle   = cle_q && seq_drive;
    assign nf_ale   = ale_q && seq_drive;
    assign nf_we_n  = !seq_we;
    assign nf_re_n  = !seq_re;
    assign nf_dq_o  = byte_q;
    assign nf_dq_oe = seq_drive;

endmodule

// File: rtl/nbr_checker.sv
module nbr_checker (
    input logic       clk,
    input logic       rst,
    input logic       host_ack,
    input logic       nf_ce_n,
    input logic       nf_cle,
    input logic       nf_ale,
    input logic       nf_we_n,
    input logic       nf_re_n,
    input logic [7:0] nf_dq_o,
    input logic       nf_dq_oe
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_dq_oe));

    assert_latch_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(nf_cle && nf_ale));

    assert_we_drives_R4: assert property (@(posedge clk) disable iff (rst)
        !nf_we_n |-> nf_dq_oe);

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(!nf_we_n && !nf_re_n));

    assert_stable_low_R8: assert property (@(posedge clk) disable iff (rst)
        (!nf_we_n && $past(!nf_we_n)) |-> ($stable(nf_dq_o) && $stable(nf_cle) && $stable(nf_ale)));

    assert_bus_release_R9: assert property (@(posedge clk) disable iff (rst)
        nf_dq_oe |-> nf_re_n);

    assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

endmodule

bind nand_reg_bridge nbr_checker i_chk (
    .clk      (clk),
    .rst      (rst),
    .host_ack (host_ack),
    .nf_ce_n  (nf_ce_n),
    .nf_cle   (nf_cle),
    .nf_ale   (nf_ale),
    .nf_we_n  (nf_we_n),
    .nf_re_n  (nf_re_n),
    .nf_dq_o  (nf_dq_o),
    .nf_dq_oe (nf_dq_oe)
);

// File: tb/test_nand_reg_bridge.sv
module test_nand_reg_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int T          = 2;
    localparam int WR_LAT     = T + T + T + 1;
    localparam int RD_LAT     = T + T + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ack;
    logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0]  nf_dq_o;
    logic [7:0]  nf_dq_i;
    logic        nf_rb_n = 1'b1;

    int checks = 0;
    int errors = 0;

    // flash model and monitor state
    int         ptr = 0;
    int         we_pulses = 0, re_pulses = 0, we_run = 0, re_run = 0;
    int         we_width = 0, re_width = 0, oe_cnt = 0, oe_re_clash = 0;
    logic       prev_we = 1'b1, prev_re = 1'b1;
    logic       last_cle, last_ale, last_ce_n;
    logic [7:0] last_byte;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_reg_bridge i_nand_reg_bridge (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_ack   (host_ack),
        .nf_ce_n    (nf_ce_n),
        .nf_cle     (nf_cle),
        .nf_ale     (nf_ale),
        .nf_we_n    (nf_we_n),
        .nf_re_n    (nf_re_n),
        .nf_dq_o    (nf_dq_o),
        .nf_dq_oe   (nf_dq_oe),
        .nf_dq_i    (nf_dq_i),
        .nf_rb_n    (nf_rb_n)
    );

    function automatic logic [7:0] flash_byte(input int p);
        return 8'h5A + 8'(p * 7);
    endfunction

    assign nf_dq_i = flash_byte(ptr);

    always @(negedge clk) begin
        if (!rst) begin
            if (nf_dq_oe) oe_cnt++;
            if (nf_dq_oe && !nf_re_n) oe_re_clash++;
            if (!nf_we_n) begin
                we_run++;
                last_cle  = nf_cle;
                last_ale  = nf_ale;
                last_ce_n = nf_ce_n;
                last_byte = nf_dq_o;
            end else if (!prev_we) begin
                we_pulses++;
                we_width = we_run;
                we_run   = 0;
            end
            if (!nf_re_n) begin
                re_run++;
            end else if (!prev_re) begin
                re_pulses++;
                re_width = re_run;
                re_run   = 0;
                ptr++;
            end
            prev_we = nf_we_n;
            prev_re = nf_re_n;
        end
    end

    task automatic clr_mon();
        we_pulses = 0; re_pulses = 0; oe_cnt = 0; oe_re_clash = 0;
        we_width = 0; re_width = 0;
    endtask

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_wdata = wd;
        lat = 0; rd = '0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            lat++;
            if (host_ack) begin
                rd = host_rdata;
                break;
            end
        end
        host_req = 1'b0;
    endtask

    function automatic logic [31:0] mkw(input logic ce, input logic [2:0] op, input logic [7:0] b);
        return {ce, op, 4'h0, b, 16'h0000};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk(nf_ce_n && nf_we_n && nf_re_n, "R1 strobes high", {nf_ce_n, nf_we_n, nf_re_n}, 3'b111);
        chk(!nf_cle && !nf_ale && !nf_dq_oe, "R1 latches low", {nf_cle, nf_ale, nf_dq_oe}, 0);
    endtask

    task automatic t_command();
        logic [31:0] rd; int lat;
        clr_mon();
        access(1'b1, mkw(1'b1, 3'd0, 8'h90), rd, lat);
        @(negedge clk);
        chk(we_pulses == 1, "R2 one pulse", we_pulses, 1);
        chk(last_cle && !last_ale, "R2 cle", {last_cle, last_ale}, 2'b10);
        chk(last_byte == 8'h90, "R2 byte", last_byte, 8'h90);
        chk(!last_ce_n, "R5 ce low", last_ce_n, 0);
        chk(we_width == T, "R8 we low width", we_width, T);
        chk(oe_cnt == 3 * T, "R8 setup+low+hold", oe_cnt, 3 * T);
        chk(lat == WR_LAT, "R12 write latency", lat, WR_LAT);
    endtask

    task automatic t_address();
        logic [31:0] rd; int lat;
        clr_mon();
        access(1'b1, mkw(1'b1, 3'd1, 8'h3B), rd, lat);
        @(negedge clk);
        chk(we_pulses == 1, "R3 one pulse", we_pulses, 1);
        chk(!last_cle && last_ale, "R3 ale", {last_cle, last_ale}, 2'b01);
        chk(last_byte == 8'h3B, "R3 byte", last_byte, 8'h3B);
    endtask

    task automatic t_write_data();
        logic [31:0] rd; int lat;
        clr_mon();
        access(1'b1, mkw(1'b1, 3'd3, 8'hE7), rd, lat);
        @(negedge clk);
        chk(we_pulses == 1, "R4 one pulse", we_pulses, 1);
        chk(!last_cle && !last_ale, "R4 no latch", {last_cle, last_ale}, 0);
        chk(last_byte == 8'hE7, "R4 byte", last_byte, 8'hE7);
        chk(nf_dq_oe == 1'b0, "R9 released after", nf_dq_oe, 0);
    endtask

    task automatic t_chip_enable();
        logic [31:0] rd; int lat;
        clr_mon();
        access(1'b1, mkw(1'b0, 3'd0, 8'hFF), rd, lat);
        @(negedge clk);
        chk(last_ce_n == 1'b1, "R5 ce high in cycle", last_ce_n, 1);
        chk(nf_ce_n == 1'b1, "R5 ce stays high", nf_ce_n, 1);
    endtask

    task automatic t_read_stream();
        logic [31:0] rd; int lat;
        int p0;
        access(1'b1, mkw(1'b1, 3'd2, 8'h00), rd, lat);
        chk(lat == 1, "R12 mode latency", lat, 1);
        for (int k = 0; k < 3; k++) begin
            clr_mon();
            p0 = ptr;
            access(1'b0, '0, rd, lat);
            @(negedge clk);
            chk(rd[23:16] == flash_byte(p0), "R6 stream byte", rd[23:16], flash_byte(p0));
            chk(re_pulses == 1, "R6 one re pulse", re_pulses, 1);
            chk(re_width == T, "R8 re low width", re_width, T);
            chk(lat == RD_LAT, "R12 read latency", lat, RD_LAT);
            chk(oe_re_clash == 0 && oe_cnt == 0, "R9 bus off in read", oe_cnt, 0);
            chk(rd[31:24] == 0 && rd[14:0] == 0, "R7 zero bits", rd, rd[23:15] << 15);
        end
    endtask

    task automatic t_busy();
        logic [31:0] rd; int lat;
        nf_rb_n = 1'b0;
        access(1'b0, '0, rd, lat);
        chk(rd[15] == 1'b1, "R7 busy", rd[15], 1);
        nf_rb_n = 1'b1;
        access(1'b0, '0, rd, lat);
        chk(rd[15] == 1'b0, "R7 ready", rd[15], 0);
    endtask

    task automatic t_leave_read();
        logic [31:0] rd; int lat;
        logic [7:0] held;
        held = flash_byte(ptr - 1);
        access(1'b1, mkw(1'b1, 3'd3, 8'hC3), rd, lat);
        clr_mon();
        access(1'b0, '0, rd, lat);
        @(negedge clk);
        chk(re_pulses == 0, "R10 no re pulse", re_pulses, 0);
        chk(rd[23:16] == held, "R10 held byte", rd[23:16], held);
        chk(lat == 1, "R12 plain read latency", lat, 1);
    endtask

    task automatic t_ignored_ops();
        logic [31:0] rd; int lat;
        clr_mon();
        access(1'b1, mkw(1'b0, 3'd5, 8'h11), rd, lat);
        @(negedge clk);
        chk(nf_ce_n == 1'b1, "R11 ce off", nf_ce_n, 1);
        access(1'b1, mkw(1'b1, 3'd7, 8'h22), rd, lat);
        @(negedge clk);
        chk(nf_ce_n == 1'b0, "R11 ce on", nf_ce_n, 0);
        access(1'b1, mkw(1'b1, 3'd4, 8'h33), rd, lat);
        access(1'b1, mkw(1'b1, 3'd6, 8'h44), rd, lat);
        @(negedge clk);
        chk(we_pulses == 0 && re_pulses == 0, "R11 no strobe", we_pulses + re_pulses, 0);
        chk(oe_cnt == 0, "R11 bus idle", oe_cnt, 0);
        chk(lat == 1, "R12 ignored latency", lat, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(nf_ce_n && nf_we_n && nf_re_n && !nf_dq_oe, "R1 during reset", nf_ce_n, 1);
        rst = 1'b0;
        t_reset();
        t_command();
        t_address();
        t_write_data();
        t_chip_enable();
        t_read_stream();
        t_busy();
        t_leave_read();
        t_ignored_ops();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule